// File: doc/BRIEF.md
# Keyed Watchdog Counter

This block is a supervisory up-counter that has to be serviced, or it will trip. It counts prescaled clock ticks upward from a programmed reload value. When it passes the all-ones value it wraps back to the reload value. The wrap drives a reset strobe low for one prescaled period and raises an overflow interrupt. A second compare value, the delay threshold, gives an early warning. When the running counter reaches it, a delay interrupt is flagged. Software can then service the watchdog before the wrap.

Software reaches the block through a simple single-cycle write port. The port has a 4-bit register select and 32 bits of data. Current state comes back on dedicated output pins. The run state can be changed only by a two-write key handshake on a dedicated key register. Any other write in between cancels the handshake. Configuration values are frozen while the counter runs. The service action is a write to a refresh register with a fresh value.

Top module: `wdog_unlock`

## Requirements
- R1: After a synchronous reset the block is stopped. The counter, the status bits and the enable bits read zero, and `irq_n` and `wdt_rst_n` are high.
- R2: A key-register write (select 5) whose low 16 bits are BBBBh, followed by the next write being a key-register write of 4444h in the low 16 bits, sets the running state at that second write.
- R3: A key-register write of AAAAh followed by a next write of 5555h (low 16 bits) clears the running state.
- R4: The upper 16 data bits of a key write are ignored. If the write after a first key is anything else, the sequence is abandoned and the running state is unchanged. Such a write may be a different value, a repeat of the first key, or a write to another select.
- R5: Control (select 0) bit 3 enables the prescaler and bits 2:0 hold n. When it is enabled, the running counter advances once every 2^n clocks; when it is disabled, it advances every clock.
- R6: An advance from all-ones reloads the counter from the load register (select 1). `wdt_rst_n` then stays low for exactly one prescaled period, starting at that edge.
- R7: The wrap sets status bit 0. A running advance whose new value equals the delay register (select 3) sets status bit 1.
- R8: Writing 1 to a bit of the status register (select 6) clears it. Writing 0 leaves it unchanged.
- R9: Select 7 sets enable bits and select 8 clears them, each by writing 1. `irq_n` is low exactly when some status bit and its enable are both 1, including when the enable is set after the status.
- R10: While running, writes to control, load, counter (select 2) and delay are ignored.
- R11: A refresh write (select 4) whose value differs from the last stored refresh value reloads the counter from the load register and restarts the prescaler. An equal value has no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 4 | Register select |
| wr_data | input | 32 | Write data |
| count_o | output | 32 | Current counter value |
| running_o | output | 1 | Run state |
| status_o | output | 2 | Pending events: bit 0 wrap, bit 1 delay |
| irq_en_o | output | 2 | Interrupt enables |
| irq_n | output | 1 | Active-low interrupt line |
| wdt_rst_n | output | 1 | Active-low reset strobe |

## Verification
The properties rely on one assumption about writes. The run state can change only at a key write that carries the matching second key. The counter can change while stopped only at a counter or refresh write. The stimulus keeps to this by using only the write port, one write per cycle, with no force or hierarchical poke. The load value sits well below all-ones, so a wrap can never land back on the overflow value. This keeps the reset strobe to a single prescaled period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [3:0] {
    SEL_CTRL  = 4'd0,
    SEL_LOAD  = 4'd1,
    SEL_COUNT = 4'd2,
    SEL_DELAY = 4'd3,
    SEL_TRIG  = 4'd4,
    SEL_KEY   = 4'd5,
    SEL_STAT  = 4'd6,
    SEL_ENSET = 4'd7,
    SEL_ENCLR = 4'd8
  } wsel_e;

  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_STOP_A  = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_STOP_B  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_START_A = 16'hBBBB;
  localparam logic [KEY_W-1:0] KEY_START_B = 16'h4444;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_STOP  = 2'd1,
    KS_START = 2'd2
  } kstate_e;

  localparam int NUM_EV = 2;
endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             is_key,
  input  logic [KEY_W-1:0] key_val,
  output logic             start_p,
  output logic             stop_p
);
  kstate_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= KS_IDLE;
    end else if (wr_en) begin
      if (is_key && st_q == KS_IDLE) begin
        if (key_val == KEY_STOP_A)       st_q <= KS_STOP;
        else if (key_val == KEY_START_A) st_q <= KS_START;
        else                             st_q <= KS_IDLE;
      end else begin
        st_q <= KS_IDLE;
      end
    end
  end

  assign start_p = wr_en && is_key && st_q == KS_START && key_val == KEY_START_B;
  assign stop_p  = wr_en && is_key && st_q == KS_STOP  && key_val == KEY_STOP_B;
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            restart,
  input  logic            ps_en,
  input  logic [PS_W-1:0] ps_n,
  output logic            tick
);
  localparam int PC_W = (1 << PS_W) - 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W:0]   ratio;
  logic [PC_W:0]   limit_w;
  logic [PC_W-1:0] limit;

  always_comb begin
    ratio   = {{PC_W{1'b0}}, 1'b1} << ps_n;
    limit_w = ratio - {{PC_W{1'b0}}, 1'b1};
    limit   = ps_en ? limit_w[PC_W-1:0] : '0;
  end

  assign tick = run && (pc_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || restart || tick) pc_q <= '0;
    else                                pc_q <= pc_q + {{(PC_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/wdog_irq.sv
module wdog_irq #(
  parameter int NEV = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] ev,
  input  logic           clr_wr,
  input  logic           set_en_wr,
  input  logic           clr_en_wr,
  input  logic [NEV-1:0] wdata,
  output logic [NEV-1:0] status,
  output logic [NEV-1:0] enable,
  output logic           irq_n
);
  logic [NEV-1:0] stat_d, en_d;

  always_comb begin
    for (int i = 0; i < NEV; i++) begin
      stat_d[i] = ev[i] | (status[i] & ~(clr_wr & wdata[i]));
      en_d[i]   = (enable[i] | (set_en_wr & wdata[i])) & ~(clr_en_wr & wdata[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      irq_n  <= 1'b1;
    end else begin
      status <= stat_d;
      enable <= en_d;
      irq_n  <= ~|(stat_d & en_d);
    end
  end
endmodule

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [31:0]      wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic [1:0]       status_o,
  output logic [1:0]       irq_en_o,
  output logic             irq_n,
  output logic             wdt_rst_n
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             ps_en_q;
  logic [PS_W-1:0]  ps_n_q;
  logic [CNT_W-1:0] load_q, cnt_q, dly_q, trig_q, cnt_adv;
  logic             run_q, rstn_q;
  logic             start_p, stop_p, tick, wrap, trig_hit, cfg_ok;
  logic [NUM_EV-1:0] ev;

  function automatic logic sel(input logic [3:0] a, input wsel_e s);
    return wr_en && (a == s);
  endfunction

  wdog_keyseq u_keys (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .is_key  (wr_addr == SEL_KEY),
    .key_val (wr_data[KEY_W-1:0]),
    .start_p (start_p),
    .stop_p  (stop_p)
  );

  assign trig_hit = sel(wr_addr, SEL_TRIG) && (wr_data[CNT_W-1:0] != trig_q);

  wdog_prescale #(.PS_W(PS_W)) u_ps (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .restart (trig_hit),
    .ps_en   (ps_en_q),
    .ps_n    (ps_n_q),
    .tick    (tick)
  );

  assign wrap    = tick && (cnt_q == CNT_MAX);
  assign cnt_adv = wrap ? load_q : cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  assign cfg_ok  = !run_q;
  assign ev[0]   = wrap && !trig_hit;
  assign ev[1]   = tick && !trig_hit && (cnt_adv == dly_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      ps_en_q <= 1'b0;
      ps_n_q  <= '0;
      load_q  <= '0;
      dly_q   <= '0;
      trig_q  <= '0;
    end else begin
      if (start_p)     run_q <= 1'b1;
      else if (stop_p) run_q <= 1'b0;
      if (cfg_ok && sel(wr_addr, SEL_CTRL)) begin
        ps_n_q  <= wr_data[PS_W-1:0];
        ps_en_q <= wr_data[PS_W];
      end
      if (cfg_ok && sel(wr_addr, SEL_LOAD))  load_q <= wr_data[CNT_W-1:0];
      if (cfg_ok && sel(wr_addr, SEL_DELAY)) dly_q  <= wr_data[CNT_W-1:0];
      if (sel(wr_addr, SEL_TRIG))            trig_q <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (trig_hit) begin
      cnt_q <= load_q;
    end else if (tick) begin
      cnt_q <= cnt_adv;
    end else if (cfg_ok && sel(wr_addr, SEL_COUNT)) begin
      cnt_q <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    rstn_q <= 1'b1;
    else if (ev[0])             rstn_q <= 1'b0;
    else if (tick || !run_q)    rstn_q <= 1'b1;
  end

  wdog_irq #(.NEV(NUM_EV)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .clr_wr    (sel(wr_addr, SEL_STAT)),
    .set_en_wr (sel(wr_addr, SEL_ENSET)),
    .clr_en_wr (sel(wr_addr, SEL_ENCLR)),
    .wdata     (wr_data[NUM_EV-1:0]),
    .status    (status_o),
    .enable    (irq_en_o),
    .irq_n     (irq_n)
  );

  assign count_o   = cnt_q;
  assign running_o = run_q;
  assign wdt_rst_n = rstn_q;
endmodule

// File: rtl/wdog_unlock_chk.sv
module wdog_unlock_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [3:0]       wr_addr,
  input logic [31:0]      wr_data,
  input logic [CNT_W-1:0] count_o,
  input logic             running_o,
  input logic [1:0]       status_o,
  input logic [1:0]       irq_en_o,
  input logic             irq_n,
  input logic             wdt_rst_n
);
  // R2: running only rises at a write of the second start key
  a_r2_start_key: assert property (@(posedge clk) disable iff (rst)
    $rose(running_o) |-> $past(wr_en && wr_addr == 4'd5 && wr_data[15:0] == 16'h4444));

  // R3: running only falls at a write of the second stop key
  a_r3_stop_key: assert property (@(posedge clk) disable iff (rst)
    $fell(running_o) |-> $past(wr_en && wr_addr == 4'd5 && wr_data[15:0] == 16'h5555));

  // R6: the reset strobe only falls after the counter sat at all-ones
  a_r6_strobe_on_wrap: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_rst_n) |-> ($past(count_o) == {CNT_W{1'b1}}) && $past(running_o));

  // R7: a wrap flags overflow status
  a_r7_wrap_flag: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_rst_n) |-> status_o[0]);

  // R9: interrupt line tracks pending and enabled events
  a_r9_irq_line: assert property (@(posedge clk) disable iff (rst)
    irq_n == !(|(status_o & irq_en_o)));

  // R10: a stopped counter moves only by counter or refresh writes
  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    (!running_o && !(wr_en && (wr_addr == 4'd2 || wr_addr == 4'd4))) |=> $stable(count_o));
endmodule

bind wdog_unlock wdog_unlock_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .count_o   (count_o),
  .running_o (running_o),
  .status_o  (status_o),
  .irq_en_o  (irq_en_o),
  .irq_n     (irq_n),
  .wdt_rst_n (wdt_rst_n)
);

// File: tb/wdog_unlock_tb.sv
module wdog_unlock_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] count_o;
  logic        running_o, irq_n, wdt_rst_n;
  logic [1:0]  status_o, irq_en_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit model_on = 1'b0;

  always #2.5 clk = ~clk;

  wdog_unlock u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_o(count_o), .running_o(running_o), .status_o(status_o),
    .irq_en_o(irq_en_o), .irq_n(irq_n), .wdt_rst_n(wdt_rst_n)
  );

  // behavioural reference state
  bit        m_run, m_psen, m_irqn, m_rstn;
  int        m_psn, m_pc, m_key;
  bit [31:0] m_cnt, m_load, m_dly, m_trig;
  bit [1:0]  m_stat, m_en;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_run = 0; m_psen = 0; m_psn = 0; m_pc = 0; m_key = 0;
      m_cnt = 0; m_load = 0; m_dly = 0; m_trig = 0;
      m_stat = 0; m_en = 0; m_irqn = 1; m_rstn = 1;
    end else begin
      int ratio;
      bit tick, hit, wrap;
      bit [31:0] nxt;
      bit [1:0] ev;
      bit go, halt;
      ratio = m_psen ? (1 << m_psn) : 1;
      tick  = m_run && (m_pc == ratio - 1);
      hit   = wr_en && wr_addr == 4 && wr_data != m_trig;
      wrap  = tick && m_cnt == 32'hFFFF_FFFF;
      nxt   = wrap ? m_load : m_cnt + 1;
      ev[0] = wrap && !hit;
      ev[1] = tick && !hit && nxt == m_dly;
      go = 0; halt = 0;
      if (wr_en) begin
        if (wr_addr == 5 && m_key == 2 && wr_data[15:0] == 16'h4444) go = 1;
        if (wr_addr == 5 && m_key == 1 && wr_data[15:0] == 16'h5555) halt = 1;
        if (wr_addr == 5 && m_key == 0 && wr_data[15:0] == 16'hAAAA) m_key = 1;
        else if (wr_addr == 5 && m_key == 0 && wr_data[15:0] == 16'hBBBB) m_key = 2;
        else m_key = 0;
      end
      if (ev[0]) m_rstn = 0; else if (tick || !m_run) m_rstn = 1;
      if (hit) m_cnt = m_load;
      else if (tick) m_cnt = nxt;
      else if (!m_run && wr_en && wr_addr == 2) m_cnt = wr_data;
      if (!m_run || hit || tick) m_pc = 0; else m_pc++;
      if (wr_en && wr_addr == 6) m_stat = m_stat & ~wr_data[1:0];
      m_stat = m_stat | ev;
      if (wr_en && wr_addr == 7) m_en = m_en | wr_data[1:0];
      if (wr_en && wr_addr == 8) m_en = m_en & ~wr_data[1:0];
      m_irqn = !(|(m_stat & m_en));
      if (!m_run && wr_en) begin
        if (wr_addr == 0) begin m_psn = int'(wr_data[2:0]); m_psen = wr_data[3]; end
        if (wr_addr == 1) m_load = wr_data;
        if (wr_addr == 3) m_dly = wr_data;
      end
      if (wr_en && wr_addr == 4) m_trig = wr_data;
      if (go) m_run = 1; else if (halt) m_run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      chk(count_o == m_cnt, "R5 count vs model", count_o, m_cnt);
      chk(running_o == m_run, "R2 run vs model", running_o, m_run);
      chk(status_o == m_stat, "R7 status vs model", status_o, m_stat);
      chk(irq_en_o == m_en, "R9 enable vs model", irq_en_o, m_en);
      chk(irq_n == m_irqn, "R9 irq_n vs model", irq_n, m_irqn);
      chk(wdt_rst_n == m_rstn, "R6 strobe vs model", wdt_rst_n, m_rstn);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    model_on = 1'b1;
    // R1 reset state
    chk(!running_o && count_o == 0 && status_o == 0 && irq_en_o == 0, "R1 reset regs",
        {running_o, status_o, irq_en_o}, 0);
    chk(irq_n && wdt_rst_n, "R1 reset lines", {irq_n, wdt_rst_n}, 2'b11);

    wr(0, 32'h0000_000A);          // prescaler on, n=2 -> ratio 4
    wr(1, 32'hFFFF_FFF0);
    wr(2, 32'hFFFF_FFF0);
    wr(3, 32'hFFFF_FFF8);
    wr(7, 32'h3);

    // R4 broken sequences
    wr(5, 32'h0000_BBBB); wr(0, 32'h0000_000A); wr(5, 32'h0000_4444);
    chk(!running_o, "R4 other select between keys", running_o, 0);
    wr(5, 32'h0000_BBBB); wr(5, 32'h0000_1234); wr(5, 32'h0000_4444);
    chk(!running_o, "R4 wrong second key", running_o, 0);
    // R2 start with junk upper bits (R4 upper ignored)
    wr(5, 32'hFFFF_BBBB); wr(5, 32'h0001_4444);
    chk(running_o, "R2 start sequence", running_o, 1);

    // R10 writes ignored while running
    wr(2, 32'h5); wr(1, 32'h7);
    chk(count_o != 32'h5, "R10 count write ignored", count_o, 32'hFFFF_FFF0);

    idle(34);
    chk(status_o[1] && !irq_n, "R7 delay flag", status_o, 2);

    // R6 wrap and strobe width
    while (wdt_rst_n) @(negedge clk);
    chk(count_o == 32'hFFFF_FFF0, "R6 reload after wrap", count_o, 32'hFFFF_FFF0);
    chk(status_o[0], "R7 overflow flag", status_o, 3);
    begin
      int w = 0;
      while (!wdt_rst_n && w < 300) begin w++; @(negedge clk); end
      chk(w == 4, "R6 strobe width", w, 4);
    end

    // R9 enable handling
    wr(8, 32'h3);
    chk(irq_n && status_o == 2'b11, "R9 cleared enables", irq_n, 1);
    wr(7, 32'h1);
    chk(!irq_n, "R9 enable after status", irq_n, 0);
    // R8 write-one-to-clear
    wr(6, 32'h1);
    chk(status_o == 2'b10 && irq_n, "R8 clear bit0 only", status_o, 2);
    wr(6, 32'h0);
    chk(status_o == 2'b10, "R8 zero write keeps", status_o, 2);

    // R11 refresh, and R10 load unchanged
    wr(4, 32'h1);
    chk(count_o == 32'hFFFF_FFF0, "R11 refresh reload", count_o, 32'hFFFF_FFF0);
    idle(5);
    wr(4, 32'h1);
    chk(count_o == 32'hFFFF_FFF1, "R11 same value no reload", count_o, 32'hFFFF_FFF1);

    // R4 repeated first key then R3 stop
    wr(5, 32'h0000_AAAA); wr(5, 32'h0000_AAAA); wr(5, 32'h0000_5555);
    chk(running_o, "R4 repeated first key", running_o, 1);
    wr(5, 32'h0000_AAAA); wr(5, 32'h0000_5555);
    chk(!running_o, "R3 stop sequence", running_o, 0);

    // R5 prescaler off
    wr(0, 32'h0); wr(2, 32'h100);
    wr(5, 32'hBBBB); wr(5, 32'h4444);
    begin
      logic [31:0] a;
      idle(2); a = count_o; idle(8);
      chk(count_o - a == 8, "R5 ratio 1", count_o - a, 8);
      wr(5, 32'hAAAA); wr(5, 32'h5555);
      wr(0, 32'hB);
      wr(5, 32'hBBBB); wr(5, 32'h4444);
      idle(3); a = count_o; idle(8);
      chk(count_o - a == 1, "R5 ratio 8", count_o - a, 1);
    end
    idle(20);
    model_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule